// File: doc/BRIEF.md
# Audio Port Status and Interrupt Register Bank

This block is the 32-bit register file that software uses to drive an audio serial port. It turns writes to a command word into level enables for the receiver, the transmitter and the audio clock. It turns one-cycle event pulses from the receive and transmit datapaths into sticky status flags. It combines those flags with a software-managed mask into a single interrupt line.

Status is never written directly. Software clears flags by writing ones to a clear register and forces error flags by writing ones to a set register. The mask works the same way, through separate enable and disable registers. Each receive overrun and transmit underrun also latches a per-slot bit chosen by the slot index that comes with the event, so software can see which of the time slots failed.

The bus is a simple word-addressed strobe interface. Register k sits at byte offset 4k, and `busWordAddr` carries k. Read data is registered.

Top module: `audio_irq_regbank`

## Requirements
- R1: After reset, all outputs are 0, and the status, mask and mode registers read 0.
- R2: A write to the command register (word 0) acts on the bits that are 1. Bit 0 turns the receiver on and bit 1 turns it off. Bit 2 turns the clock on and bit 3 turns it off. Bit 4 turns the transmitter on and bit 5 turns it off. When on and off are both 1 for the same unit, off wins. The command register reads as 0.
- R3: In the status register (word 2), bit 0 mirrors the receiver enable and bit 4 mirrors the transmitter enable.
- R4: An overrun pulse sets status bit 2 and bit 8+slot. An underrun pulse sets status bit 6 and bit 20+slot. All of these bits are sticky.
- R5: A ready pulse from the receiver sets status bit 1, and a read of word 8 clears it. A ready pulse from the transmitter sets status bit 5, and a write to word 9 clears it.
- R6: Writing ones to word 3 clears the matching bits among 1, 2, 5, 6, 15:8 and 27:20. An event that arrives in the same cycle wins over the clear.
- R7: Writing ones to word 4 sets the matching bits among 2, 6, 15:8 and 27:20. All other status bits are left unchanged.
- R8: Writing ones to word 5 sets mask bits, and writing ones to word 6 clears them. The mask reads back at word 7. Only bits 1, 2, 5 and 6 of the mask exist.
- R9: `irqOut` is 1 exactly when some status bit among 1, 2, 5 and 6 and its mask bit are both 1.
- R10: The mode register (word 1) is a 32-bit read/write register. Word 10 reads the parameter VERSION_ID. Writes to words 2, 7, 8 and 10 have no effect. Reads of unmapped words return 0.
- R11: A command write with bit 7 set clears status, mask, enables and mode at the next clock edge and raises `swResetPulse` for the following cycle. The other command bits in that same write are ignored.
- R12: Read data appears on `busRdData` in the cycle after `busRdEn` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWordAddr | input | ADDR_W | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| rxReadyEvt | input | 1 | Receive sample ready pulse |
| rxOverrunEvt | input | 1 | Receive overrun pulse |
| rxOverrunSlot | input | SLOT_W | Slot index of the overrun |
| txReadyEvt | input | 1 | Transmit ready pulse |
| txUnderrunEvt | input | 1 | Transmit underrun pulse |
| txUnderrunSlot | input | SLOT_W | Slot index of the underrun |
| irqOut | output | 1 | Combined interrupt |
| rxEnable | output | 1 | Receiver enable level |
| txEnable | output | 1 | Transmitter enable level |
| clkEnable | output | 1 | Audio clock enable level |
| swResetPulse | output | 1 | One-cycle software reset pulse |

## Verification
The hardest situation to reach is a datapath event that lands in the same cycle as a software clear of the same flag, because it needs a bus write and an event pulse on one edge. The stimulus raises an overrun pulse at the same falling edge that starts a clear write, and then reads the status to confirm that the flag and its slot bit survived. The same approach of driving inputs together covers the command write that sets on and off for one unit at once, and a software reset issued while enables are being requested.

// File: rtl/audio_regbank_pkg.sv
package audio_regbank_pkg;

  localparam int REG_W = 32;

  // word indices (byte offset = 4 * index)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_MODE  = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_SCLR  = 3;
  localparam int IDX_SSET  = 4;
  localparam int IDX_IEN   = 5;
  localparam int IDX_IDIS  = 6;
  localparam int IDX_IMSK  = 7;
  localparam int IDX_RHOLD = 8;
  localparam int IDX_THOLD = 9;
  localparam int IDX_VER   = 10;
  localparam int NUM_REGS  = 11;

  // command bits
  localparam int CMD_RX_ON   = 0;
  localparam int CMD_RX_OFF  = 1;
  localparam int CMD_CLK_ON  = 2;
  localparam int CMD_CLK_OFF = 3;
  localparam int CMD_TX_ON   = 4;
  localparam int CMD_TX_OFF  = 5;
  localparam int CMD_SWRST   = 7;

  // status bits
  localparam int ST_RX_EN    = 0;
  localparam int ST_RX_RDY   = 1;
  localparam int ST_RX_OVR   = 2;
  localparam int ST_TX_EN    = 4;
  localparam int ST_TX_RDY   = 5;
  localparam int ST_TX_UND   = 6;
  localparam int RX_SLOT_LSB = 8;
  localparam int TX_SLOT_LSB = 20;
  localparam int MAX_SLOTS   = 8;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MODE,
    RD_STAT,
    RD_MASK,
    RD_VER
  } rdSel_t;

  typedef struct packed {
    logic             rxOn;
    logic             rxOff;
    logic             clkOn;
    logic             clkOff;
    logic             txOn;
    logic             txOff;
    logic             swReset;
    logic             modeWr;
    logic             clrWr;
    logic             setWr;
    logic             ienWr;
    logic             idisWr;
    logic             rxPop;
    logic             txPush;
    logic             rdEn;
    rdSel_t           rdSel;
    logic [REG_W-1:0] wdata;
  } ctlStrobes_t;

endpackage

// File: rtl/audio_regbank_decode.sv
module audio_regbank_decode
  import audio_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busWordAddr,
  input  logic [REG_W-1:0]  busWrData,
  output ctlStrobes_t       strb
);

  logic [NUM_REGS-1:0] wrHit;
  logic [NUM_REGS-1:0] rdHit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign wrHit[r] = busWrEn && (busWordAddr == ADDR_W'(r));
    assign rdHit[r] = busRdEn && (busWordAddr == ADDR_W'(r));
  end

  always_comb begin
    strb         = '0;
    strb.wdata   = busWrData;
    strb.rxOn    = wrHit[IDX_CTRL] && busWrData[CMD_RX_ON];
    strb.rxOff   = wrHit[IDX_CTRL] && busWrData[CMD_RX_OFF];
    strb.clkOn   = wrHit[IDX_CTRL] && busWrData[CMD_CLK_ON];
    strb.clkOff  = wrHit[IDX_CTRL] && busWrData[CMD_CLK_OFF];
    strb.txOn    = wrHit[IDX_CTRL] && busWrData[CMD_TX_ON];
    strb.txOff   = wrHit[IDX_CTRL] && busWrData[CMD_TX_OFF];
    strb.swReset = wrHit[IDX_CTRL] && busWrData[CMD_SWRST];
    strb.modeWr  = wrHit[IDX_MODE];
    strb.clrWr   = wrHit[IDX_SCLR];
    strb.setWr   = wrHit[IDX_SSET];
    strb.ienWr   = wrHit[IDX_IEN];
    strb.idisWr  = wrHit[IDX_IDIS];
    strb.txPush  = wrHit[IDX_THOLD];
    strb.rxPop   = rdHit[IDX_RHOLD];
    strb.rdEn    = busRdEn;
    if (rdHit[IDX_MODE])      strb.rdSel = RD_MODE;
    else if (rdHit[IDX_STAT]) strb.rdSel = RD_STAT;
    else if (rdHit[IDX_IMSK]) strb.rdSel = RD_MASK;
    else if (rdHit[IDX_VER])  strb.rdSel = RD_VER;
    else                      strb.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/audio_regbank_state.sv
module audio_regbank_state
  import audio_regbank_pkg::*;
#(
  parameter int          NUM_SLOTS  = 8,
  parameter int          SLOT_W     = 3,
  parameter logic [31:0] VERSION_ID = 32'h0000_0142
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              rxReadyEvt,
  input  logic              rxOverrunEvt,
  input  logic [SLOT_W-1:0] rxOverrunSlot,
  input  logic              txReadyEvt,
  input  logic              txUnderrunEvt,
  input  logic [SLOT_W-1:0] txUnderrunSlot,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              clkEnable,
  output logic              swResetPulse,
  output logic              irqOut,
  output logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  maskWord,
  output logic [REG_W-1:0]  busRdData
);

  logic [NUM_SLOTS-1:0] rxSlotQ;
  logic [NUM_SLOTS-1:0] txSlotQ;
  logic rxRdyQ, rxOvrQ, txRdyQ, txUndQ;
  logic [3:0] maskQ;  // {txUnd, txRdy, rxOvr, rxRdy}
  logic [REG_W-1:0] modeQ;

  // per-slot sticky error bits
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic rxSet, rxClr, txSet, txClr;
    logic rxQ, txQ;
    assign rxSet = (rxOverrunEvt && (rxOverrunSlot == SLOT_W'(s)))
                || (strb.setWr && strb.wdata[RX_SLOT_LSB+s]);
    assign rxClr = strb.clrWr && strb.wdata[RX_SLOT_LSB+s];
    assign txSet = (txUnderrunEvt && (txUnderrunSlot == SLOT_W'(s)))
                || (strb.setWr && strb.wdata[TX_SLOT_LSB+s]);
    assign txClr = strb.clrWr && strb.wdata[TX_SLOT_LSB+s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxQ <= 1'b0;
        txQ <= 1'b0;
      end else if (strb.swReset) begin
        rxQ <= 1'b0;
        txQ <= 1'b0;
      end else begin
        rxQ <= rxSet | (rxQ & ~rxClr);
        txQ <= txSet | (txQ & ~txClr);
      end
    end

    assign rxSlotQ[s] = rxQ;
    assign txSlotQ[s] = txQ;
  end

  // summary flag set/clear terms
  logic rxRdySet, rxRdyClr, rxOvrSet, rxOvrClr;
  logic txRdySet, txRdyClr, txUndSet, txUndClr;
  logic [3:0] maskOn, maskOff;

  always_comb begin
    rxRdySet = rxReadyEvt;
    rxRdyClr = (strb.clrWr && strb.wdata[ST_RX_RDY]) || strb.rxPop;
    rxOvrSet = rxOverrunEvt || (strb.setWr && strb.wdata[ST_RX_OVR]);
    rxOvrClr = strb.clrWr && strb.wdata[ST_RX_OVR];
    txRdySet = txReadyEvt;
    txRdyClr = (strb.clrWr && strb.wdata[ST_TX_RDY]) || strb.txPush;
    txUndSet = txUnderrunEvt || (strb.setWr && strb.wdata[ST_TX_UND]);
    txUndClr = strb.clrWr && strb.wdata[ST_TX_UND];
    maskOn   = {4{strb.ienWr}} & {strb.wdata[ST_TX_UND], strb.wdata[ST_TX_RDY],
                                  strb.wdata[ST_RX_OVR], strb.wdata[ST_RX_RDY]};
    maskOff  = {4{strb.idisWr}} & {strb.wdata[ST_TX_UND], strb.wdata[ST_TX_RDY],
                                   strb.wdata[ST_RX_OVR], strb.wdata[ST_RX_RDY]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRdyQ       <= 1'b0;
      rxOvrQ       <= 1'b0;
      txRdyQ       <= 1'b0;
      txUndQ       <= 1'b0;
      maskQ        <= '0;
      modeQ        <= '0;
      rxEnable     <= 1'b0;
      txEnable     <= 1'b0;
      clkEnable    <= 1'b0;
      swResetPulse <= 1'b0;
    end else begin
      swResetPulse <= strb.swReset;
      if (strb.swReset) begin
        rxRdyQ    <= 1'b0;
        rxOvrQ    <= 1'b0;
        txRdyQ    <= 1'b0;
        txUndQ    <= 1'b0;
        maskQ     <= '0;
        modeQ     <= '0;
        rxEnable  <= 1'b0;
        txEnable  <= 1'b0;
        clkEnable <= 1'b0;
      end else begin
        rxRdyQ <= rxRdySet | (rxRdyQ & ~rxRdyClr);
        rxOvrQ <= rxOvrSet | (rxOvrQ & ~rxOvrClr);
        txRdyQ <= txRdySet | (txRdyQ & ~txRdyClr);
        txUndQ <= txUndSet | (txUndQ & ~txUndClr);
        maskQ  <= (maskQ | maskOn) & ~maskOff;
        if (strb.modeWr) modeQ <= strb.wdata;
        if (strb.rxOff)      rxEnable <= 1'b0;
        else if (strb.rxOn)  rxEnable <= 1'b1;
        if (strb.txOff)      txEnable <= 1'b0;
        else if (strb.txOn)  txEnable <= 1'b1;
        if (strb.clkOff)     clkEnable <= 1'b0;
        else if (strb.clkOn) clkEnable <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ST_RX_EN]  = rxEnable;
    statusWord[ST_RX_RDY] = rxRdyQ;
    statusWord[ST_RX_OVR] = rxOvrQ;
    statusWord[ST_TX_EN]  = txEnable;
    statusWord[ST_TX_RDY] = txRdyQ;
    statusWord[ST_TX_UND] = txUndQ;
    statusWord[RX_SLOT_LSB +: NUM_SLOTS] = rxSlotQ;
    statusWord[TX_SLOT_LSB +: NUM_SLOTS] = txSlotQ;

    maskWord = '0;
    maskWord[ST_RX_RDY] = maskQ[0];
    maskWord[ST_RX_OVR] = maskQ[1];
    maskWord[ST_TX_RDY] = maskQ[2];
    maskWord[ST_TX_UND] = maskQ[3];
  end

  assign irqOut = |(statusWord & maskWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strb.rdEn) begin
      unique case (strb.rdSel)
        RD_MODE: busRdData <= modeQ;
        RD_STAT: busRdData <= statusWord;
        RD_MASK: busRdData <= maskWord;
        RD_VER:  busRdData <= VERSION_ID;
        default: busRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/audio_irq_regbank.sv
module audio_irq_regbank
  import audio_regbank_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          NUM_SLOTS  = 8,
  parameter logic [31:0] VERSION_ID = 32'h0000_0142,
  localparam int         SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busWordAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              rxReadyEvt,
  input  logic              rxOverrunEvt,
  input  logic [SLOT_W-1:0] rxOverrunSlot,
  input  logic              txReadyEvt,
  input  logic              txUnderrunEvt,
  input  logic [SLOT_W-1:0] txUnderrunSlot,
  output logic              irqOut,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              clkEnable,
  output logic              swResetPulse
);

  ctlStrobes_t      strb;
  logic [REG_W-1:0] statusWord;
  logic [REG_W-1:0] maskWord;

  audio_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .busWordAddr (busWordAddr),
    .busWrData   (busWrData),
    .strb        (strb)
  );

  audio_regbank_state #(
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_W     (SLOT_W),
    .VERSION_ID (VERSION_ID)
  ) u_state (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .rxReadyEvt     (rxReadyEvt),
    .rxOverrunEvt   (rxOverrunEvt),
    .rxOverrunSlot  (rxOverrunSlot),
    .txReadyEvt     (txReadyEvt),
    .txUnderrunEvt  (txUnderrunEvt),
    .txUnderrunSlot (txUnderrunSlot),
    .rxEnable       (rxEnable),
    .txEnable       (txEnable),
    .clkEnable      (clkEnable),
    .swResetPulse   (swResetPulse),
    .irqOut         (irqOut),
    .statusWord     (statusWord),
    .maskWord       (maskWord),
    .busRdData      (busRdData)
  );

endmodule

// File: rtl/audio_irq_regbank_chk.sv
module audio_irq_regbank_chk #(
  parameter int          ADDR_W     = 6,
  parameter int          NUM_SLOTS  = 8,
  parameter int          SLOT_W     = 3,
  parameter logic [31:0] VERSION_ID = 32'h0000_0142
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busWordAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              rxOverrunEvt,
  input logic [SLOT_W-1:0] rxOverrunSlot,
  input logic              txUnderrunEvt,
  input logic [SLOT_W-1:0] txUnderrunSlot,
  input logic              irqOut,
  input logic              rxEnable,
  input logic              swResetPulse,
  input logic [31:0]       statusWord,
  input logic [31:0]       maskWord
);

  logic cmdWr;
  logic rstReq;
  assign cmdWr  = busWrEn && (busWordAddr == '0);
  assign rstReq = cmdWr && busWrData[7];

  AST_SWRST_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swResetPulse) |-> $past(rstReq)); // R11

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> (statusWord == 32'h0 && maskWord == 32'h0 && !irqOut)); // R11

  AST_RXEN_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> $past(cmdWr && busWrData[0] && !busWrData[1] && !busWrData[7])); // R2

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrunEvt && !rstReq) |=> (statusWord[2] && statusWord[8 + $past(rxOverrunSlot)])); // R4

  AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrunEvt && !rstReq) |=> (statusWord[6] && statusWord[20 + $past(txUnderrunSlot)])); // R4

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskWord != 32'h0)); // R9

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busWordAddr == ADDR_W'(10)) |=> (busRdData == VERSION_ID)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn && $past(rstN)) |=> $stable(busRdData)); // R12

endmodule

bind audio_irq_regbank audio_irq_regbank_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_SLOTS  (NUM_SLOTS),
  .SLOT_W     (SLOT_W),
  .VERSION_ID (VERSION_ID)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .busWrEn        (busWrEn),
  .busRdEn        (busRdEn),
  .busWordAddr    (busWordAddr),
  .busWrData      (busWrData),
  .busRdData      (busRdData),
  .rxOverrunEvt   (rxOverrunEvt),
  .rxOverrunSlot  (rxOverrunSlot),
  .txUnderrunEvt  (txUnderrunEvt),
  .txUnderrunSlot (txUnderrunSlot),
  .irqOut         (irqOut),
  .rxEnable       (rxEnable),
  .swResetPulse   (swResetPulse),
  .statusWord     (statusWord),
  .maskWord       (maskWord)
);

// File: tb/audio_irq_regbank_bench.sv
module audio_irq_regbank_bench;

  localparam logic [31:0] VER = 32'h0000_0142;
  localparam int ADDR_W = 6;

  // word indices
  localparam logic [5:0] A_CMD = 6'd0, A_MODE = 6'd1, A_STAT = 6'd2, A_SCLR = 6'd3,
                         A_SSET = 6'd4, A_IEN = 6'd5, A_IDIS = 6'd6, A_IMSK = 6'd7,
                         A_RHOLD = 6'd8, A_THOLD = 6'd9, A_VER = 6'd10, A_NONE = 6'd15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [ADDR_W-1:0] busWordAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic rxReadyEvt = 1'b0, rxOverrunEvt = 1'b0, txReadyEvt = 1'b0, txUnderrunEvt = 1'b0;
  logic [2:0] rxOverrunSlot = '0, txUnderrunSlot = '0;
  logic irqOut, rxEnable, txEnable, clkEnable, swResetPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  audio_irq_regbank #(.ADDR_W(ADDR_W), .NUM_SLOTS(8), .VERSION_ID(VER)) u_audio_irq_regbank (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxReadyEvt(rxReadyEvt), .rxOverrunEvt(rxOverrunEvt), .rxOverrunSlot(rxOverrunSlot),
    .txReadyEvt(txReadyEvt), .txUnderrunEvt(txUnderrunEvt), .txUnderrunSlot(txUnderrunSlot),
    .irqOut(irqOut), .rxEnable(rxEnable), .txEnable(txEnable),
    .clkEnable(clkEnable), .swResetPulse(swResetPulse)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, A_CMD,  32'h15,       32'h0,        8'd2},  // R2 rx, clk, tx on
    '{1'b0, A_STAT, 32'h0,        32'h11,       8'd3},  // R3
    '{1'b1, A_CMD,  32'h02,       32'h0,        8'd2},  // R2 rx off
    '{1'b0, A_STAT, 32'h0,        32'h10,       8'd3},  // R3
    '{1'b1, A_CMD,  32'h01,       32'h0,        8'd2},
    '{1'b0, A_STAT, 32'h0,        32'h11,       8'd2},
    '{1'b1, A_CMD,  32'h03,       32'h0,        8'd2},  // R2 off wins
    '{1'b0, A_STAT, 32'h0,        32'h10,       8'd2},
    '{1'b1, A_SSET, 32'hFFFFFFFF, 32'h0,        8'd7},  // R7
    '{1'b0, A_STAT, 32'h0,        32'h0FF0FF54, 8'd7},
    '{1'b1, A_SCLR, 32'h00000F04, 32'h0,        8'd6},  // R6 partial clear
    '{1'b0, A_STAT, 32'h0,        32'h0FF0F050, 8'd6},
    '{1'b1, A_SCLR, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, A_STAT, 32'h0,        32'h10,       8'd6},
    '{1'b1, A_STAT, 32'hFFFFFFFF, 32'h0,        8'd10}, // R10 read-only status
    '{1'b0, A_STAT, 32'h0,        32'h10,       8'd10},
    '{1'b1, A_IEN,  32'hFFFFFFFF, 32'h0,        8'd8},  // R8
    '{1'b0, A_IMSK, 32'h0,        32'h66,       8'd8},
    '{1'b1, A_IDIS, 32'h24,       32'h0,        8'd8},
    '{1'b0, A_IMSK, 32'h0,        32'h42,       8'd8},
    '{1'b1, A_IMSK, 32'hFF,       32'h0,        8'd10}, // R10 read-only mask
    '{1'b0, A_IMSK, 32'h0,        32'h42,       8'd10},
    '{1'b1, A_MODE, 32'hDEADBEEF, 32'h0,        8'd10},
    '{1'b0, A_MODE, 32'h0,        32'hDEADBEEF, 8'd10},
    '{1'b1, A_VER,  32'h1234,     32'h0,        8'd10},
    '{1'b0, A_VER,  32'h0,        VER,          8'd10},
    '{1'b0, A_CMD,  32'h0,        32'h0,        8'd2},  // R2 command reads 0
    '{1'b0, A_NONE, 32'h0,        32'h0,        8'd10},
    '{1'b0, A_RHOLD,32'h0,        32'h0,        8'd10}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busWordAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1", "outputs", {27'd0, irqOut, rxEnable, txEnable, clkEnable, swResetPulse}, 32'h0);
    busRead(A_STAT, rd); chk("R1", "status", rd, 32'h0);
    busRead(A_IMSK, rd); chk("R1", "mask", rd, 32'h0);
    busRead(A_MODE, rd); chk("R1", "mode", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) busWrite(VECS[i].addr, VECS[i].data);
      else begin
        busRead(VECS[i].addr, rd);
        chk($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), rd, VECS[i].exp);
      end
    end

    // R2 enable levels at ports: rx off, tx on, clk on, then clk off
    chk("R2", "enables", {29'd0, rxEnable, txEnable, clkEnable}, 32'h3);
    busWrite(A_CMD, 32'h08);
    chk("R2", "clk off", {31'd0, clkEnable}, 32'h0);

    // R4 / R9 underrun on slots 7 and 0, mask bit 6 is set
    @(negedge clk); txUnderrunEvt = 1'b1; txUnderrunSlot = 3'd7;
    @(negedge clk); txUnderrunEvt = 1'b0;
    chk("R9", "irq on underrun", {31'd0, irqOut}, 32'h1);
    busRead(A_STAT, rd); chk("R4", "underrun slot7", rd, 32'h08000050);
    @(negedge clk); txUnderrunEvt = 1'b1; txUnderrunSlot = 3'd0;
    @(negedge clk); txUnderrunEvt = 1'b0;
    busRead(A_STAT, rd); chk("R4", "underrun slot0", rd, 32'h08100050);

    // R6 clear summary only, slot bits stay; R9 irq drops
    busWrite(A_SCLR, 32'h40);
    chk("R9", "irq after clear", {31'd0, irqOut}, 32'h0);
    busRead(A_STAT, rd); chk("R6", "summary cleared", rd, 32'h08100010);

    // R5 receive ready and drain
    @(negedge clk); rxReadyEvt = 1'b1;
    @(negedge clk); rxReadyEvt = 1'b0;
    chk("R9", "irq on rx ready", {31'd0, irqOut}, 32'h1);
    busRead(A_RHOLD, rd);
    busRead(A_STAT, rd); chk("R5", "rx ready drained", rd, 32'h08100010);

    // R5 transmit ready and refill
    @(negedge clk); txReadyEvt = 1'b1;
    @(negedge clk); txReadyEvt = 1'b0;
    busRead(A_STAT, rd); chk("R5", "tx ready set", rd, 32'h08100030);
    busWrite(A_THOLD, 32'h0);
    busRead(A_STAT, rd); chk("R5", "tx ready cleared", rd, 32'h08100010);

    // R6 event wins over same-cycle clear
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = A_SCLR; busWrData = 32'h00000804;
    rxOverrunEvt = 1'b1; rxOverrunSlot = 3'd3;
    @(negedge clk);
    busWrEn = 1'b0; rxOverrunEvt = 1'b0;
    busRead(A_STAT, rd); chk("R6", "event beats clear", rd, 32'h08100814);

    // R12 read data holds after the strobe drops
    busRead(A_VER, rd);
    @(negedge clk);
    chk("R12", "read hold", busRdData, VER);

    // R11 software reset with enable bits in the same write
    busWrite(A_CMD, 32'h95);
    chk("R11", "pulse and enables", {27'd0, swResetPulse, irqOut, rxEnable, txEnable, clkEnable}, 32'h10);
    @(negedge clk);
    chk("R11", "pulse width", {31'd0, swResetPulse}, 32'h0);
    busRead(A_STAT, rd); chk("R11", "status cleared", rd, 32'h0);
    busRead(A_IMSK, rd); chk("R11", "mask cleared", rd, 32'h0);
    busRead(A_MODE, rd); chk("R11", "mode cleared", rd, 32'h0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule